// File: doc/BRIEF.md
# GPIO Pin-Selectable Interrupt Controller

This block turns a bank of already-synchronized GPIO inputs into a small set of interrupt lines. Each line chooses one GPIO as its source through a 7-bit select code. It can fire on the level of that pin, on one edge, or on both edges, and a per-line inversion bit picks active-low level or falling edge. Level mode gives a steady output that follows the pin. The edge modes give a pulse one clock long.

Software sets the block up through a plain 32-bit register port with a write strobe, a byte address and write data. Reads are registered. One control word holds a global enable and three 8-bit per-line fields. Four select words each carry the source codes for two lines. Nothing fires until the global enable is set. Select codes beyond the last pin never raise a line.

Top module: `gpio_irq_sel`

## Requirements
- R1: The word at byte offset 0x00 holds the global enable in bit 31, the per-line both-edge bits in 23:16, the per-line single-edge bits in 15:8 and the per-line inversion bits in 7:0 (bit n of each field belongs to line n). These bits read back as written.
- R2: Select words sit at byte offsets 0x04, 0x08, 0x0C and 0x10. The word at 0x04+4k holds the source of line 2k in bits 6:0 and of line 2k+1 in bits 22:16. `rdata` shows the word addressed in one cycle at the next clock edge.
- R3: With both-edge and single-edge clear, a line is a level output equal to its selected pin XOR its inversion bit, registered once (visible after the clock edge that samples the pin).
- R4: With single-edge set and both-edge clear, a line pulses for one cycle after a rising edge of its pin (inversion bit 0) or a falling edge (inversion bit 1), and is low otherwise.
- R5: With both-edge set, the single-edge and inversion bits have no effect, and the line pulses for one cycle after every change of its pin.
- R6: While the global enable is 0, all interrupt outputs are 0 in the following cycle, whatever the pins and modes.
- R7: A select code from 62 to 127 never asserts its line in any mode or polarity.
- R8: In the first cycle after a line's select code changes, no edge is reported for that line, even if the old and new pins differ in value or the new pin changes.
- R9: Reserved bits of mapped words read as 0 and ignore writes. Unmapped or unaligned byte addresses (offsets 0x14 to 0x1C, or any address with bits 1:0 not zero) read as 0, and writes to them change nothing.
- R10: Reset clears every register, so all reads return 0 and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address for read and write |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Registered read data for `addr` |
| gpio_i | input | 62 | Synchronized GPIO inputs |
| irq_o | output | 8 | Interrupt outputs, one per line |

## Verification
The bench builds the block with its default parameters: 62 pins, 8 lines and 7-bit select codes. At that size every select code from 0 to 127 can be swept, which covers the whole undefined range. A one and a zero can also be walked across all 62 pins in level mode with both polarities. Long pseudo-random pin sequences run in the single-edge, both-edge and mixed-mode configurations. Reselections are checked against steady and changing pins. The bench checks each line's output every cycle against a model of the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned PIN_CNT  = 62;
  localparam int unsigned LINE_CNT = 8;
  localparam int unsigned SEL_W    = 7;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 5;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE1 = 2'd1,
    TRIG_EDGE2 = 2'd2
  } trig_mode_e;

  // both-edge outranks single-edge, which outranks level
  function automatic trig_mode_e pick_mode(input logic both, input logic single);
    if (both)        return TRIG_EDGE2;
    else if (single) return TRIG_EDGE1;
    else             return TRIG_LEVEL;
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int unsigned LINES = 8,
  parameter int unsigned SEL_W = 7,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic                        en_o,
  output logic [LINES-1:0]            both_o,
  output logic [LINES-1:0]            single_o,
  output logic [LINES-1:0]            pol_o,
  output logic [LINES-1:0][SEL_W-1:0] sel_o
);

  localparam int unsigned IDX_W      = AW - 2;
  localparam int unsigned SEL_REGS   = LINES / 2;
  localparam int unsigned EN_BIT     = 31;
  localparam int unsigned BOTH_LSB   = 16;
  localparam int unsigned SINGLE_LSB = 8;
  localparam int unsigned POL_LSB    = 0;
  localparam int unsigned ODD_LSB    = 16;

  logic [IDX_W-1:0] widx;
  logic             aligned;
  logic [DW-1:0]    rd_word;

  assign widx    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= 1'b0;
      both_o   <= '0;
      single_o <= '0;
      pol_o    <= '0;
      sel_o    <= '0;
    end else if (wr_en && aligned) begin
      if (widx == '0) begin
        en_o     <= wdata[EN_BIT];
        both_o   <= wdata[BOTH_LSB +: LINES];
        single_o <= wdata[SINGLE_LSB +: LINES];
        pol_o    <= wdata[POL_LSB +: LINES];
      end
      for (int k = 0; k < SEL_REGS; k++) begin
        if (widx == IDX_W'(k + 1)) begin
          sel_o[2*k]   <= wdata[0 +: SEL_W];
          sel_o[2*k+1] <= wdata[ODD_LSB +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if (widx == '0) begin
        rd_word[EN_BIT]                = en_o;
        rd_word[BOTH_LSB +: LINES]     = both_o;
        rd_word[SINGLE_LSB +: LINES]   = single_o;
        rd_word[POL_LSB +: LINES]      = pol_o;
      end
      for (int k = 0; k < SEL_REGS; k++) begin
        if (widx == IDX_W'(k + 1)) begin
          rd_word[0 +: SEL_W]       = sel_o[2*k];
          rd_word[ODD_LSB +: SEL_W] = sel_o[2*k+1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS  = 62,
  parameter int unsigned SEL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PINS-1:0]  gpio_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             both_i,
  input  logic             single_i,
  input  logic             pol_i,
  output logic             irq_o
);

  localparam int unsigned PAD_W = 2 ** SEL_W;

  logic [PAD_W-1:0] pins_pad;
  logic             src_ok;
  logic             cur;
  logic             prev_q;
  logic [SEL_W-1:0] sel_q;
  logic             same_src;
  logic             rise;
  logic             fall;
  logic             hit;
  trig_mode_e       mode;

  assign pins_pad = PAD_W'(gpio_i);
  assign src_ok   = (int'(sel_i) < PINS);
  assign cur      = src_ok & pins_pad[sel_i];
  assign same_src = (sel_i == sel_q);
  assign rise     = same_src & ~prev_q & cur;
  assign fall     = same_src & prev_q & ~cur;
  assign mode     = pick_mode(both_i, single_i);

  always_comb begin
    case (mode)
      TRIG_EDGE2: hit = rise | fall;
      TRIG_EDGE1: hit = pol_i ? fall : rise;
      default:    hit = src_ok & (cur ^ pol_i);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= cur;
      sel_q  <= sel_i;
      irq_o  <= en_i & hit;
    end
  end

  // R7: undefined source codes keep the line quiet
  a_r7_undef_src: assert property (@(posedge clk) disable iff (rst)
    (int'(sel_i) >= PINS) |=> !irq_o);

  // R5: any change of a steady source in both-edge mode pulses
  a_r5_both_edge: assert property (@(posedge clk) disable iff (rst)
    (en_i && both_i && same_src && (cur != prev_q)) |=> irq_o);

  // R4: rising edge with inversion clear pulses in single-edge mode
  a_r4_rise_edge: assert property (@(posedge clk) disable iff (rst)
    (en_i && !both_i && single_i && !pol_i && same_src && !prev_q && cur) |=> irq_o);

  // R8: reselection cycle reports no edge
  a_r8_no_reselect_edge: assert property (@(posedge clk) disable iff (rst)
    (!same_src && (both_i || single_i)) |=> !irq_o);

endmodule

// File: rtl/gpio_irq_sel.sv
module gpio_irq_sel
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS   = PIN_CNT,
  parameter int unsigned LINES  = LINE_CNT,
  parameter int unsigned SW     = SEL_W,
  parameter int unsigned DW     = REG_W,
  parameter int unsigned AW     = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [PINS-1:0]  gpio_i,
  output logic [LINES-1:0] irq_o
);

  logic                     ctrl_en;
  logic [LINES-1:0]         both;
  logic [LINES-1:0]         single;
  logic [LINES-1:0]         pol;
  logic [LINES-1:0][SW-1:0] sel;

  gpio_irq_regs #(
    .LINES (LINES),
    .SEL_W (SW),
    .DW    (DW),
    .AW    (AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .en_o     (ctrl_en),
    .both_o   (both),
    .single_o (single),
    .pol_o    (pol),
    .sel_o    (sel)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    gpio_irq_line #(
      .PINS  (PINS),
      .SEL_W (SW)
    ) u_line (
      .clk      (clk),
      .rst      (rst),
      .gpio_i   (gpio_i),
      .sel_i    (sel[l]),
      .en_i     (ctrl_en),
      .both_i   (both[l]),
      .single_i (single[l]),
      .pol_i    (pol[l]),
      .irq_o    (irq_o[l])
    );
  end

  // R6: global enable clear silences every line next cycle
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (irq_o == '0));

endmodule

// File: tb/gpio_irq_sel_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_sel_tb_top;

  localparam int NP = 62;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] gpio_i = '0;
  logic [NL-1:0] irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0]   m_ctrl;
  logic [6:0]    m_sel [NL];
  bit            pend  [NL];
  logic [NP-1:0] gv, pg;
  logic [63:0]   lfsr = 64'h9E37_79B9_7F4A_7C15;

  gpio_irq_sel dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gpio_i(gpio_i), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NP-1:0] nxt();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr[NP-1:0];
  endfunction

  function automatic logic exp_line(input int l);
    int s;
    logic c, p, pl;
    s  = int'(m_sel[l]);
    pl = m_ctrl[l];
    if (!m_ctrl[31] || s >= NP) return 1'b0;
    c = gv[s];
    p = pg[s];
    if (m_ctrl[16+l]) return !pend[l] && (c != p);
    if (m_ctrl[8+l])  return !pend[l] && (pl ? (p && !c) : (!p && c));
    return c ^ pl;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    addr = 5'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    for (int l = 0; l < NL; l++) pend[l] = 0;
    if (a == 0) m_ctrl = d & 32'h80FF_FFFF;
    else if (a >= 4 && a <= 16 && (a % 4) == 0) begin
      int k;
      k = (a - 4) / 4;
      if (m_sel[2*k]   != d[6:0])   pend[2*k]   = 1;
      if (m_sel[2*k+1] != d[22:16]) pend[2*k+1] = 1;
      m_sel[2*k]   = d[6:0];
      m_sel[2*k+1] = d[22:16];
    end
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    addr = 5'(a);
    @(posedge clk); @(negedge clk);
    for (int l = 0; l < NL; l++) pend[l] = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic step(input logic [NP-1:0] g, input string tag);
    pg = gv; gv = g; gpio_i = g;
    @(posedge clk); @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk(tag, 32'(irq_o[l]), 32'(exp_line(l)));
      pend[l] = 0;
    end
  endtask

  task automatic set_sel(input logic [6:0] s [NL]);
    for (int k = 0; k < NL/2; k++)
      wr(4 + 4*k, {9'b0, s[2*k+1], 9'b0, s[2*k]});
  endtask

  task automatic set_all_sel(input logic [6:0] v);
    logic [6:0] s [NL];
    for (int l = 0; l < NL; l++) s[l] = v;
    set_sel(s);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [6:0] s [NL];
    m_ctrl = '0; gv = '0; pg = '0;
    for (int l = 0; l < NL; l++) begin m_sel[l] = '0; pend[l] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10: reset state
    chk("R10 irq after reset", 32'(irq_o), 32'h0);
    for (int a = 0; a < 32; a += 4) rd(a, 32'h0, "R10 reset readback");

    // R1 R2 R9: readback masks and ignored writes
    for (int a = 0; a < 32; a += 4) wr(a, 32'hFFFF_FFFF);
    rd(0, 32'h80FF_FFFF, "R1 ctrl all ones");
    for (int a = 4; a <= 16; a += 4) rd(a, 32'h007F_007F, "R2 select all ones");
    for (int a = 20; a < 32; a += 4) rd(a, 32'h0, "R9 unmapped reads zero");
    for (int a = 20; a < 32; a += 4) wr(a, 32'h0);
    wr(1, 32'h0); wr(6, 32'h0);
    rd(0, 32'h80FF_FFFF, "R9 unmapped write ignored ctrl");
    for (int a = 4; a <= 16; a += 4) rd(a, 32'h007F_007F, "R9 unmapped write ignored sel");
    rd(5, 32'h0, "R9 unaligned read zero");
    wr(0, 32'h7F12_3456);
    rd(0, 32'h0012_3456, "R1 R9 ctrl reserved");
    wr(8, 32'hABCD_1234);
    rd(8, 32'h004D_0034, "R2 R9 select reserved");

    // R3: level mode, walking one and zero
    wr(0, 32'h8000_0000);
    for (int l = 0; l < NL; l++) s[l] = 7'(l*8 + 3);
    set_sel(s);
    step('0, "R3 level idle");
    for (int p = 0; p < NP; p++) step(NP'(1) << p, "R3 level walk one");
    wr(0, 32'h8000_00FF);
    for (int p = 0; p < NP; p++) step(~(NP'(1) << p), "R3 level inverted walk zero");
    wr(0, 32'h8000_00A5);
    for (int i = 0; i < 60; i++) step(nxt(), "R3 level mixed polarity");

    // R4: single-edge
    wr(0, 32'h8000_FF0F);
    for (int i = 0; i < 150; i++) step(nxt(), "R4 single edge");

    // R5: both-edge priority over single and polarity
    wr(0, 32'h80FF_FFA5);
    for (int i = 0; i < 150; i++) step(nxt(), "R5 both edge");
    wr(0, 32'h8003_0C5A);
    for (int i = 0; i < 150; i++) step(nxt(), "R3 R4 R5 mixed modes");

    // R6: global enable clear
    wr(0, 32'h00FF_0000);
    for (int i = 0; i < 40; i++) step(nxt(), "R6 disabled both edge");
    wr(0, 32'h0000_00FF);
    for (int i = 0; i < 20; i++) step(nxt(), "R6 disabled level low");

    // R7: every select code
    wr(0, 32'h8000_00FF);
    for (int v = 0; v < 128; v++) begin
      set_all_sel(7'(v));
      step('0, "R7 code sweep active low");
    end
    wr(0, 32'h8000_0000);
    for (int v = 0; v < 128; v++) begin
      set_all_sel(7'(v));
      step('1, "R7 code sweep active high");
    end
    wr(0, 32'h80FF_0000);
    set_all_sel(7'd100);
    for (int i = 0; i < 30; i++) step(nxt(), "R7 undefined both edge");

    // R8: reselection suppresses false edges
    for (int i = 0; i < NP; i++) gv[i] = (i % 2 == 0);
    step(gv, "R8 setup");
    set_all_sel(7'd0);
    step(gv, "R8 steady on pin 0");
    set_all_sel(7'd1);
    step(gv, "R8 both edge reselect high to low");
    step(gv, "R8 steady after reselect");
    wr(0, 32'h8000_FF00);
    set_all_sel(7'd2);
    step(gv, "R8 single rise reselect low to high");
    set_all_sel(7'd5);
    step(gv ^ (NP'(1) << 5), "R8 reselect with changing pin");
    step(gv, "R8 edge after reselect settles");
    wr(0, 32'h80FF_0000);
    for (int i = 0; i < 40; i++) begin
      for (int l = 0; l < NL; l++) s[l] = 7'((i*7 + l*11) % NP);
      set_sel(s);
      step(nxt(), "R8 repeated reselect");
      step(nxt(), "R5 after reselect");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule